// File: doc/BRIEF.md
# Cache Hit/Miss Profiling Counters

This unit observes the lookup activity of an instruction cache and a data cache and keeps running totals of accesses and misses for each. Every lookup arrives as a one-cycle access strobe, an optional miss strobe and a one-hot tag naming the external memory region that was addressed. Software programs a separate region mask for each cache. Only events whose tag meets the mask of their own cache are counted, so profiling can cover any chosen subset of regions.

The access and miss counters are free-running and wrap around. When an access counter wraps, the miss count of the same cache is copied into a snapshot register, so that software can still form a ratio over a full wrap period. Software reads the counters over a small word-addressed register port and works out miss rates itself. A typical session writes the masks, sets the enable bit and then issues a clear.

Top module: `cache_prof_unit`

## Requirements
- R1: After reset the control word, all four counters and both snapshot registers read as zero.
- R2: The control word sits at byte offset 0x00. Bit 0 is the count enable. Bits 12:8 hold the instruction region mask and bits 20:16 hold the data region mask, and all of these read back as written. Bit 1 is a clear command and always reads as zero.
- R3: While enable is set, an access strobe increments that cache's access counter by one when its region tag ANDed with the cache's mask is nonzero. Several mask bits may be set together.
- R4: An access whose tag shares no bit with its cache's mask leaves both counters of that cache unchanged.
- R5: While enable is clear, no counter changes, whatever the strobes and tags are.
- R6: A miss strobe increments the miss counter only in a cycle where the same cache's access is counted. A miss strobe without a counted access has no effect.
- R7: Writing the control word with bit 1 set zeroes all four counters at that clock edge. This works while enable is set, and it wins over any increment in the same cycle.
- R8: Counters are CNT_W bits wide and wrap from all-ones to zero. When an access counter wraps, the snapshot register of the same cache takes the miss count held just before that edge.
- R9: A clear leaves both snapshot registers unchanged.
- R10: Read offsets are 0x04 instruction accesses, 0x08 instruction misses, 0x0C data accesses, 0x10 data misses, 0x14 instruction snapshot and 0x18 data snapshot. Writes to these offsets have no effect. A read of offset 0x1C returns zero.
- R11: The two caches are independent. Events and masks of one cache never change the counters or the snapshot of the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ic_acc_i | input | 1 | Instruction cache lookup strobe |
| ic_miss_i | input | 1 | Instruction cache miss strobe |
| ic_region_i | input | NUM_REG | One-hot region tag of the instruction lookup |
| dc_acc_i | input | 1 | Data cache lookup strobe |
| dc_miss_i | input | 1 | Data cache miss strobe |
| dc_region_i | input | NUM_REG | One-hot region tag of the data lookup |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register byte address |
| reg_wdata_i | input | DATA_W | Register write data |
| reg_rdata_o | output | DATA_W | Register read data for reg_addr_i, combinational |

## Verification
The counting path is driven with tags inside the mask, tags outside it and a mask with several regions set. This separates a correct AND-reduce from an exact-match compare and from a missing filter. Miss strobes are sent both with and without a qualifying access, which shows whether misses are gated by the access. A reduced counter width lets a wrap happen in a few hundred cycles, so the bench can check the captured snapshot value, the wrapped count and the untouched other side. Clear is issued alone, together with an increment and after a wrap, which separates its priority from its effect on the snapshots.

// File: rtl/cprof_pkg.sv
package cprof_pkg;
  localparam int unsigned SIDE_I = 0;
  localparam int unsigned SIDE_D = 1;
  localparam int unsigned NUM_SIDES = 2;

  localparam int unsigned IDX_W = 3;
  localparam logic [IDX_W-1:0] IDX_CTRL  = 3'd0;
  localparam logic [IDX_W-1:0] IDX_IACC  = 3'd1;
  localparam logic [IDX_W-1:0] IDX_IMISS = 3'd2;
  localparam logic [IDX_W-1:0] IDX_DACC  = 3'd3;
  localparam logic [IDX_W-1:0] IDX_DMISS = 3'd4;
  localparam logic [IDX_W-1:0] IDX_ISNAP = 3'd5;
  localparam logic [IDX_W-1:0] IDX_DSNAP = 3'd6;

  localparam int unsigned EN_BIT    = 0;
  localparam int unsigned CLR_BIT   = 1;
  localparam int unsigned IMASK_LSB = 8;
  localparam int unsigned DMASK_LSB = 16;
endpackage

// File: rtl/cprof_ctrl.sv
module cprof_ctrl
  import cprof_pkg::*;
#(
  parameter int unsigned NUM_REG = 5,
  parameter int unsigned DATA_W  = 32
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         wr_i,
  input  logic [IDX_W-1:0]             idx_i,
  input  logic [DATA_W-1:0]            wdata_i,
  output logic                         en_o,
  output logic                         clr_o,
  output logic [NUM_SIDES-1:0][NUM_REG-1:0] mask_o
);
  logic ctrl_wr;
  assign ctrl_wr = wr_i && (idx_i == IDX_CTRL);
  // clear is a command, not state
  assign clr_o = ctrl_wr && wdata_i[CLR_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o   <= 1'b0;
      mask_o <= '0;
    end else if (ctrl_wr) begin
      en_o           <= wdata_i[EN_BIT];
      mask_o[SIDE_I] <= wdata_i[IMASK_LSB +: NUM_REG];
      mask_o[SIDE_D] <= wdata_i[DMASK_LSB +: NUM_REG];
    end
  end
endmodule

// File: rtl/cprof_side.sv
module cprof_side #(
  parameter int unsigned NUM_REG = 5,
  parameter int unsigned CNT_W   = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic               clr_i,
  input  logic [NUM_REG-1:0] mask_i,
  input  logic               acc_i,
  input  logic               miss_i,
  input  logic [NUM_REG-1:0] region_i,
  output logic [CNT_W-1:0]   acc_cnt_o,
  output logic [CNT_W-1:0]   miss_cnt_o,
  output logic [CNT_W-1:0]   snap_o
);
  logic acc_q, miss_q, wrap;

  assign acc_q  = en_i && acc_i && (|(region_i & mask_i));
  assign miss_q = acc_q && miss_i;
  assign wrap   = acc_q && (&acc_cnt_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_cnt_o  <= '0;
      miss_cnt_o <= '0;
    end else if (clr_i) begin
      acc_cnt_o  <= '0;
      miss_cnt_o <= '0;
    end else begin
      if (acc_q)  acc_cnt_o  <= acc_cnt_o + 1'b1;
      if (miss_q) miss_cnt_o <= miss_cnt_o + 1'b1;
    end
  end

  // snapshot takes the pre-edge miss count; a suppressed (cleared) wrap captures nothing
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              snap_o <= '0;
    else if (wrap && !clr_i)  snap_o <= miss_cnt_o;
  end
endmodule

// File: rtl/cprof_rmux.sv
module cprof_rmux
  import cprof_pkg::*;
#(
  parameter int unsigned NUM_REG = 5,
  parameter int unsigned CNT_W   = 32,
  parameter int unsigned DATA_W  = 32
) (
  input  logic [IDX_W-1:0]                  idx_i,
  input  logic                              en_i,
  input  logic [NUM_SIDES-1:0][NUM_REG-1:0] mask_i,
  input  logic [NUM_SIDES-1:0][CNT_W-1:0]   acc_cnt_i,
  input  logic [NUM_SIDES-1:0][CNT_W-1:0]   miss_cnt_i,
  input  logic [NUM_SIDES-1:0][CNT_W-1:0]   snap_i,
  output logic [DATA_W-1:0]                 rdata_o
);
  logic [CNT_W-1:0] cnt_sel;
  logic             is_cnt;

  always_comb begin
    cnt_sel = '0;
    is_cnt  = 1'b1;
    unique case (idx_i)
      IDX_IACC:  cnt_sel = acc_cnt_i[SIDE_I];
      IDX_IMISS: cnt_sel = miss_cnt_i[SIDE_I];
      IDX_DACC:  cnt_sel = acc_cnt_i[SIDE_D];
      IDX_DMISS: cnt_sel = miss_cnt_i[SIDE_D];
      IDX_ISNAP: cnt_sel = snap_i[SIDE_I];
      IDX_DSNAP: cnt_sel = snap_i[SIDE_D];
      default:   is_cnt  = 1'b0;
    endcase
  end

  always_comb begin
    rdata_o = '0;
    if (is_cnt) begin
      rdata_o[CNT_W-1:0] = cnt_sel;
    end else if (idx_i == IDX_CTRL) begin
      rdata_o[EN_BIT]                 = en_i;
      rdata_o[IMASK_LSB +: NUM_REG]   = mask_i[SIDE_I];
      rdata_o[DMASK_LSB +: NUM_REG]   = mask_i[SIDE_D];
    end
  end
endmodule

// File: rtl/cache_prof_unit.sv
module cache_prof_unit
  import cprof_pkg::*;
#(
  parameter int unsigned NUM_REG = 5,
  parameter int unsigned CNT_W   = 32,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ADDR_W  = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ic_acc_i,
  input  logic               ic_miss_i,
  input  logic [NUM_REG-1:0] ic_region_i,
  input  logic               dc_acc_i,
  input  logic               dc_miss_i,
  input  logic [NUM_REG-1:0] dc_region_i,
  input  logic               reg_wr_i,
  input  logic [ADDR_W-1:0]  reg_addr_i,
  input  logic [DATA_W-1:0]  reg_wdata_i,
  output logic [DATA_W-1:0]  reg_rdata_o
);
  logic [IDX_W-1:0]                  idx;
  logic                              en, clr;
  logic [NUM_SIDES-1:0][NUM_REG-1:0] mask;
  logic [NUM_SIDES-1:0]              acc_v, miss_v;
  logic [NUM_SIDES-1:0][NUM_REG-1:0] region_v;
  logic [NUM_SIDES-1:0][CNT_W-1:0]   acc_cnt, miss_cnt, snap;

  assign idx = reg_addr_i[2 +: IDX_W];

  assign acc_v[SIDE_I]    = ic_acc_i;
  assign acc_v[SIDE_D]    = dc_acc_i;
  assign miss_v[SIDE_I]   = ic_miss_i;
  assign miss_v[SIDE_D]   = dc_miss_i;
  assign region_v[SIDE_I] = ic_region_i;
  assign region_v[SIDE_D] = dc_region_i;

  cprof_ctrl #(.NUM_REG(NUM_REG), .DATA_W(DATA_W)) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (reg_wr_i),
    .idx_i   (idx),
    .wdata_i (reg_wdata_i),
    .en_o    (en),
    .clr_o   (clr),
    .mask_o  (mask)
  );

  for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
    cprof_side #(.NUM_REG(NUM_REG), .CNT_W(CNT_W)) u_side (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .en_i       (en),
      .clr_i      (clr),
      .mask_i     (mask[s]),
      .acc_i      (acc_v[s]),
      .miss_i     (miss_v[s]),
      .region_i   (region_v[s]),
      .acc_cnt_o  (acc_cnt[s]),
      .miss_cnt_o (miss_cnt[s]),
      .snap_o     (snap[s])
    );
  end

  cprof_rmux #(.NUM_REG(NUM_REG), .CNT_W(CNT_W), .DATA_W(DATA_W)) u_rmux (
    .idx_i      (idx),
    .en_i       (en),
    .mask_i     (mask),
    .acc_cnt_i  (acc_cnt),
    .miss_cnt_i (miss_cnt),
    .snap_i     (snap),
    .rdata_o    (reg_rdata_o)
  );
endmodule

// File: rtl/cache_prof_unit_chk.sv
module cache_prof_unit_chk
  import cprof_pkg::*;
#(
  parameter int unsigned NUM_REG = 5,
  parameter int unsigned CNT_W   = 32,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ADDR_W  = 5
) (
  input logic                            clk_i,
  input logic                            rst_ni,
  input logic                            en,
  input logic                            clr,
  input logic [ADDR_W-1:0]               reg_addr_i,
  input logic [DATA_W-1:0]               reg_rdata_o,
  input logic [NUM_SIDES-1:0][CNT_W-1:0] acc_cnt,
  input logic [NUM_SIDES-1:0][CNT_W-1:0] miss_cnt,
  input logic [NUM_SIDES-1:0][CNT_W-1:0] snap
);
  for (genvar s = 0; s < NUM_SIDES; s++) begin : g_chk
    // R7
    p_clear_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr |=> (acc_cnt[s] == '0) && (miss_cnt[s] == '0));
    // R5
    p_hold_disabled_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!en && !clr) |=> $stable(acc_cnt[s]) && $stable(miss_cnt[s]));
    // R6
    p_miss_needs_access_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!clr ##1 (miss_cnt[s] != $past(miss_cnt[s]))) |-> (acc_cnt[s] != $past(acc_cnt[s])));
    // R8, R9
    p_snap_on_wrap_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (snap[s] != $past(snap[s])) |-> (&$past(acc_cnt[s])) && (acc_cnt[s] == '0));
  end

  // R2
  p_clr_reads_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i[2 +: IDX_W] == IDX_CTRL) |-> !reg_rdata_o[CLR_BIT]);
endmodule

bind cache_prof_unit cache_prof_unit_chk #(
  .NUM_REG(NUM_REG), .CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .en          (en),
  .clr         (clr),
  .reg_addr_i  (reg_addr_i),
  .reg_rdata_o (reg_rdata_o),
  .acc_cnt     (acc_cnt),
  .miss_cnt    (miss_cnt),
  .snap        (snap)
);

// File: tb/cache_prof_unit_tb.sv
module cache_prof_unit_tb;
  localparam int unsigned NUM_REG = 5;
  localparam int unsigned CNT_W   = 8;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned ADDR_W  = 5;

  localparam logic [ADDR_W-1:0] A_CTRL  = 5'h00;
  localparam logic [ADDR_W-1:0] A_IACC  = 5'h04;
  localparam logic [ADDR_W-1:0] A_IMISS = 5'h08;
  localparam logic [ADDR_W-1:0] A_DACC  = 5'h0C;
  localparam logic [ADDR_W-1:0] A_DMISS = 5'h10;
  localparam logic [ADDR_W-1:0] A_ISNAP = 5'h14;
  localparam logic [ADDR_W-1:0] A_DSNAP = 5'h18;
  localparam logic [ADDR_W-1:0] A_NONE  = 5'h1C;

  logic               clk_i = 1'b0;
  logic               rst_ni = 1'b0;
  logic               ic_acc_i = 1'b0, ic_miss_i = 1'b0;
  logic [NUM_REG-1:0] ic_region_i = '0;
  logic               dc_acc_i = 1'b0, dc_miss_i = 1'b0;
  logic [NUM_REG-1:0] dc_region_i = '0;
  logic               reg_wr_i = 1'b0;
  logic [ADDR_W-1:0]  reg_addr_i = '0;
  logic [DATA_W-1:0]  reg_wdata_i = '0;
  logic [DATA_W-1:0]  reg_rdata_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  cache_prof_unit #(.NUM_REG(NUM_REG), .CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dut (
    .clk_i, .rst_ni, .ic_acc_i, .ic_miss_i, .ic_region_i,
    .dc_acc_i, .dc_miss_i, .dc_region_i,
    .reg_wr_i, .reg_addr_i, .reg_wdata_i, .reg_rdata_o
  );

  function automatic logic [DATA_W-1:0] ctl(bit en, bit clr, logic [4:0] im, logic [4:0] dm);
    return (DATA_W'(dm) << 16) | (DATA_W'(im) << 8) | (DATA_W'(clr) << 1) | DATA_W'(en);
  endfunction

  task automatic check(string req, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [ADDR_W-1:0] a, logic [DATA_W-1:0] d);
    @(negedge clk_i);
    reg_wr_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_wr_i = 1'b0;
  endtask

  task automatic rd(logic [ADDR_W-1:0] a, output logic [DATA_W-1:0] d);
    reg_addr_i = a;
    #1 d = reg_rdata_o;
  endtask

  task automatic expect_reg(string req, logic [ADDR_W-1:0] a, logic [DATA_W-1:0] exp);
    logic [DATA_W-1:0] v;
    rd(a, v);
    check(req, v, exp);
  endtask

  // drive n cycles of events on both sides
  task automatic ev(int n, bit ia, bit im, logic [4:0] ir, bit da, bit dm, logic [4:0] dr);
    @(negedge clk_i);
    ic_acc_i = ia; ic_miss_i = im; ic_region_i = ir;
    dc_acc_i = da; dc_miss_i = dm; dc_region_i = dr;
    repeat (n) @(negedge clk_i);
    ic_acc_i = 0; ic_miss_i = 0; ic_region_i = '0;
    dc_acc_i = 0; dc_miss_i = 0; dc_region_i = '0;
  endtask

  task automatic t_reset;
    expect_reg("R1 ctrl", A_CTRL, 0);
    expect_reg("R1 iacc", A_IACC, 0);
    expect_reg("R1 imiss", A_IMISS, 0);
    expect_reg("R1 dacc", A_DACC, 0);
    expect_reg("R1 dmiss", A_DMISS, 0);
    expect_reg("R1 isnap", A_ISNAP, 0);
    expect_reg("R1 dsnap", A_DSNAP, 0);
  endtask

  task automatic t_ctrl;
    wr(A_CTRL, ctl(1, 1, 5'b10101, 5'b01010));
    expect_reg("R2 readback, clear reads 0", A_CTRL, ctl(1, 0, 5'b10101, 5'b01010));
  endtask

  task automatic t_count_filter;
    // imask 00101, dmask 00010
    wr(A_CTRL, ctl(1, 1, 5'b00101, 5'b00010));
    ev(3, 1, 0, 5'b00001, 0, 0, 0);
    ev(2, 1, 0, 5'b00100, 0, 0, 0);
    expect_reg("R3 multi-select counts", A_IACC, 5);
    ev(4, 1, 1, 5'b00010, 1, 1, 5'b00001);
    expect_reg("R4 ic out of mask acc", A_IACC, 5);
    expect_reg("R4 ic out of mask miss", A_IMISS, 0);
    expect_reg("R4 dc out of mask acc", A_DACC, 0);
    ev(6, 0, 0, 0, 1, 0, 5'b00010);
    expect_reg("R3 dc counts", A_DACC, 6);
    expect_reg("R11 ic untouched", A_IACC, 5);
  endtask

  task automatic t_miss;
    wr(A_CTRL, ctl(1, 1, 5'b11111, 5'b11111));
    ev(3, 1, 1, 5'b01000, 0, 0, 0);
    ev(2, 0, 1, 5'b01000, 0, 1, 5'b01000);
    expect_reg("R6 miss with access", A_IMISS, 3);
    expect_reg("R6 miss without access dc", A_DMISS, 0);
    expect_reg("R6 acc", A_IACC, 3);
  endtask

  task automatic t_enable;
    wr(A_CTRL, ctl(0, 0, 5'b11111, 5'b11111));
    ev(5, 1, 1, 5'b00001, 1, 1, 5'b00001);
    expect_reg("R5 hold iacc", A_IACC, 3);
    expect_reg("R5 hold imiss", A_IMISS, 3);
    expect_reg("R5 hold dacc", A_DACC, 0);
  endtask

  task automatic t_clear_prio;
    logic [DATA_W-1:0] v;
    wr(A_CTRL, ctl(1, 0, 5'b11111, 5'b11111));
    ev(4, 1, 1, 5'b00001, 1, 1, 5'b10000);
    expect_reg("R3 pre-clear iacc", A_IACC, 7);
    // clear together with an increment on both sides
    @(negedge clk_i);
    ic_acc_i = 1; ic_miss_i = 1; ic_region_i = 5'b00001;
    dc_acc_i = 1; dc_miss_i = 1; dc_region_i = 5'b00001;
    reg_wr_i = 1; reg_addr_i = A_CTRL; reg_wdata_i = ctl(1, 1, 5'b11111, 5'b11111);
    @(negedge clk_i);
    reg_wr_i = 0; ic_acc_i = 0; ic_miss_i = 0; dc_acc_i = 0; dc_miss_i = 0;
    rd(A_IACC, v);  check("R7 clear wins iacc", v, 0);
    rd(A_IMISS, v); check("R7 clear wins imiss", v, 0);
    rd(A_DACC, v);  check("R7 clear wins dacc", v, 0);
    rd(A_DMISS, v); check("R7 clear wins dmiss", v, 0);
  endtask

  task automatic t_wrap;
    wr(A_CTRL, ctl(1, 1, 5'b11111, 5'b11111));
    ev(10, 1, 1, 5'b00010, 0, 0, 0);
    ev(245, 1, 0, 5'b00010, 0, 0, 0);
    expect_reg("R8 at max", A_IACC, 255);
    expect_reg("R8 snap before wrap", A_ISNAP, 0);
    ev(1, 1, 1, 5'b00010, 0, 0, 0);
    expect_reg("R8 wrapped", A_IACC, 0);
    expect_reg("R8 miss after wrap", A_IMISS, 11);
    expect_reg("R8 snap pre-edge miss", A_ISNAP, 10);
    expect_reg("R11 other snap", A_DSNAP, 0);
    wr(A_CTRL, ctl(1, 1, 5'b11111, 5'b11111));
    expect_reg("R9 snap kept", A_ISNAP, 10);
    expect_reg("R7 cleared miss", A_IMISS, 0);
  endtask

  task automatic t_readonly;
    ev(2, 0, 0, 0, 1, 1, 5'b00100);
    wr(A_DACC, 32'h55);
    wr(A_DMISS, 32'h66);
    wr(A_ISNAP, 32'h77);
    expect_reg("R10 dacc ro", A_DACC, 2);
    expect_reg("R10 dmiss ro", A_DMISS, 2);
    expect_reg("R10 isnap ro", A_ISNAP, 10);
    expect_reg("R10 unmapped", A_NONE, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_ctrl();
    t_count_filter();
    t_miss();
    t_enable();
    t_clear_prio();
    t_wrap();
    t_readonly();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule